// File: doc/BRIEF.md
# Set/Reset Phase Detector with Per-Bit Sample-and-Hold

This block turns the timing offset between a reference clock and a recovered clock into a digital phase word. A rising edge on the reference input sets an internal latch. A rising edge on the compared input clears it. A fast measurement clock counts how many of its cycles the latch stays high. Once per bit period, which is a fixed number of fast-clock cycles, the block captures that count. It holds the captured value on its output until the next capture and presents it as a raw count and as a whole number of degrees.

The held word is a value sampled once per bit period, not a filtered average. The pulse ripple of the latch therefore never reaches the output. Phase movement from one bit to the next is reported without any smoothing. The count grows linearly with the offset across a full cycle of phase, so two readings calibrate it: the smallest output (zero offset) and the largest output (one fast cycle short of a full bit period).

Both edge inputs are treated as asynchronous. Each one passes a two-stage synchronizer in the fast domain before its rising edge is detected. Because both paths have the same delay, the measured width is unaffected by that delay.

Top module: `srpd_sampler_top`

## Requirements
- R1: After reset is released, a rising edge on `ref_edge_i` sets the latch. With no compared edge, the latch stays high and every later bit period reads `RATIO`, which is 360 degrees.
- R2: A rising edge on `cmp_edge_i` clears the latch. With no reference edge, the latch never sets and every period reads 0.
- R3: When both rising edges land in the same fast-clock cycle, clearing wins and the period reads 0.
- R4: Take periodic edges with period `RATIO` fast cycles, where the compared edge follows the reference edge by D cycles (taken modulo `RATIO`). In steady state the held count equals D for every D from 0 to `RATIO`-1. This holds wherever the edges fall relative to the sample instant.
- R5: The block samples every `RATIO` fast cycles. `sample_valid_o` is a one-cycle pulse, and pulses are exactly `RATIO` cycles apart. The held outputs change in the cycle that follows the internal sample instant, the same cycle in which `sample_valid_o` is high.
- R6: `phase_o` and `phase_deg_o` stay constant in every cycle in which `sample_valid_o` is low.
- R7: `phase_deg_o` equals floor(`phase_o` × 360 / `RATIO`).
- R8: While `rst` is high, `phase_o`, `phase_deg_o` and `sample_valid_o` are 0.
- R9: The latch reacts to edges only, not to levels. A reference input that stays high after the latch has been cleared does not set the latch again, so wide input pulses give the same count as narrow ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast measurement clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_edge_i | input | 1 | Reference clock (asynchronous); its rising edge sets the latch |
| cmp_edge_i | input | 1 | Recovered clock (asynchronous); its rising edge clears the latch |
| phase_o | output | $clog2(RATIO+1) | Held latch-high count for the last bit period |
| phase_deg_o | output | 9 | Held phase in whole degrees |
| sample_valid_o | output | 1 | One-cycle pulse marking a new held value |

## Verification
The in-line assertions check on every cycle the parts that are local in time:
- the latch responds to its set and clear strobes, and clear wins when both arrive together;
- each detected edge lasts one cycle;
- the window timer stays in range and never repeats a tick;
- the accumulator never passes its bound;
- the held outputs do not change between pulses;
- the degree value never exceeds 360.

Other behaviour shows only across whole bit periods, so only the bench scenarios can demonstrate it:
- the count equals the programmed offset for every offset, including when the latch-high interval straddles a sample instant;
- same-cycle edges read zero;
- a missing compared edge reads the full count;
- wide input pulses leave the result unchanged;
- pulses are spaced exactly one bit period apart.

// File: rtl/srpd_pkg.sv
package srpd_pkg;

  localparam int unsigned DEG_FULL = 360;
  localparam int unsigned DEG_W    = 9;

  // Width of a counter that must reach `limit` inclusive.
  function automatic int unsigned span_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  typedef enum logic [1:0] {
    LATCH_HOLD  = 2'b00,
    LATCH_SET   = 2'b01,
    LATCH_CLEAR = 2'b10,
    LATCH_BOTH  = 2'b11
  } latch_cmd_e;

endpackage

// File: rtl/srpd_edge_sync.sv
module srpd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o) else $error("rise lasted more than one cycle"); // R9

endmodule

// File: rtl/srpd_latch.sv
module srpd_latch
  import srpd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  latch_cmd_e cmd;
  logic       q_d;

  assign cmd = latch_cmd_e'({clr_i, set_i});

  always_comb begin
    unique case (cmd)
      LATCH_SET:   q_d = 1'b1;
      LATCH_CLEAR: q_d = 1'b0;
      LATCH_BOTH:  q_d = 1'b0;  // clear dominates
      default:     q_d = q_o;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= q_d;
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> q_o) else $error("set did not raise latch"); // R1
  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !q_o) else $error("clear did not lower latch"); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(q_o)) else $error("latch moved without edge"); // R9

endmodule

// File: rtl/srpd_window.sv
module srpd_window #(
  parameter int unsigned RATIO = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);

  localparam int unsigned TW   = (RATIO < 2) ? 1 : $clog2(RATIO);
  localparam logic [TW-1:0] LAST = TW'(RATIO - 1);

  logic [TW-1:0] pos_q;

  assign tick_o = (pos_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)         pos_q <= '0;
    else if (tick_o) pos_q <= '0;
    else             pos_q <= pos_q + 1'b1;
  end

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST) else $error("window timer out of range"); // R5
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (tick_o && RATIO > 1) |=> !tick_o) else $error("tick repeated"); // R5

endmodule

// File: rtl/srpd_hold.sv
module srpd_hold
  import srpd_pkg::*;
#(
  parameter int unsigned RATIO = 1000,
  localparam int unsigned CW   = span_bits(RATIO)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             high_i,
  input  logic             tick_i,
  output logic [CW-1:0]    phase_o,
  output logic [DEG_W-1:0] deg_o,
  output logic             valid_o
);

  localparam int unsigned PW = CW + DEG_W;

  logic [CW-1:0]    acc_q;
  logic [CW-1:0]    acc_sum;
  logic [PW-1:0]    scaled;
  logic [DEG_W-1:0] deg_d;

  assign acc_sum = acc_q + CW'(high_i);
  assign scaled  = PW'(acc_sum) * PW'(DEG_FULL);
  assign deg_d   = DEG_W'(scaled / PW'(RATIO));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      phase_o <= '0;
      deg_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= tick_i;
      if (tick_i) begin
        acc_q   <= '0;
        phase_o <= acc_sum;
        deg_o   <= deg_d;
      end else begin
        acc_q   <= acc_sum;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    acc_q <= CW'(RATIO - 1)) else $error("accumulator past bound"); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> ($stable(phase_o) && $stable(deg_o))) else $error("held word moved"); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    (valid_o && RATIO > 1) |=> !valid_o) else $error("valid not a pulse"); // R5
  AST_DEG_RANGE: assert property (@(posedge clk) disable iff (rst)
    deg_o <= DEG_W'(DEG_FULL)) else $error("degrees out of range"); // R7

endmodule

// File: rtl/srpd_sampler_top.sv
module srpd_sampler_top
  import srpd_pkg::*;
#(
  parameter int unsigned RATIO       = 1000,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW         = span_bits(RATIO)
) (
  input  logic             clk_fast,
  input  logic             rst,
  input  logic             ref_edge_i,
  input  logic             cmp_edge_i,
  output logic [CW-1:0]    phase_o,
  output logic [DEG_W-1:0] phase_deg_o,
  output logic             sample_valid_o
);

  logic ref_rise;
  logic cmp_rise;
  logic latch_q;
  logic tick;

  srpd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk(clk_fast), .rst(rst), .async_i(ref_edge_i), .rise_o(ref_rise)
  );

  srpd_edge_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk(clk_fast), .rst(rst), .async_i(cmp_edge_i), .rise_o(cmp_rise)
  );

  srpd_latch u_latch (
    .clk(clk_fast), .rst(rst), .set_i(ref_rise), .clr_i(cmp_rise), .q_o(latch_q)
  );

  srpd_window #(.RATIO(RATIO)) u_window (
    .clk(clk_fast), .rst(rst), .tick_o(tick)
  );

  srpd_hold #(.RATIO(RATIO)) u_hold (
    .clk(clk_fast), .rst(rst), .high_i(latch_q), .tick_i(tick),
    .phase_o(phase_o), .deg_o(phase_deg_o), .valid_o(sample_valid_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_fast)
    $past(rst) |-> (!sample_valid_o && phase_o == '0)) else $error("outputs not cleared"); // R8

endmodule

// File: tb/srpd_sampler_top_test.sv
`timescale 1ns/1ps
module srpd_sampler_top_test;

  localparam int unsigned P  = 100;
  localparam int unsigned CW = $clog2(P + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_in = 1'b0;
  logic          cmp_in = 1'b0;
  logic [CW-1:0] phase;
  logic [8:0]    deg;
  logic          valid;

  int tests = 0;
  int fails = 0;

  // stimulus generator state
  int  gen_d    = 0;
  int  ref_w    = 5;
  int  cmp_w    = 5;
  int  ref_at   = 17;
  bit  ref_en   = 1'b0;
  bit  cmp_en   = 1'b0;
  int  gpos     = 0;
  longint cyc   = 0;
  longint last_valid = -1;

  always #2 clk = ~clk;

  srpd_sampler_top #(.RATIO(P)) uut (
    .clk_fast(clk), .rst(rst), .ref_edge_i(ref_in), .cmp_edge_i(cmp_in),
    .phase_o(phase), .phase_deg_o(deg), .sample_valid_o(valid)
  );

  function automatic int exp_deg(input int cnt);
    return (cnt * 360) / P;
  endfunction

  function automatic bit in_pulse(input int pos, input int start, input int w);
    return ((pos - start + P) % P) < w;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // periodic edge generator, drives inputs away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    ref_in <= ref_en && in_pulse(gpos, ref_at, ref_w);
    cmp_in <= cmp_en && in_pulse(gpos, (ref_at + gen_d) % P, cmp_w);
    gpos   <= (gpos + 1) % P;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      finish_run();
    end
  end

  // R5: spacing of sample pulses
  always @(negedge clk) begin
    if (!rst && valid) begin
      if (last_valid >= 0) check("R5 pulse spacing", int'(cyc - last_valid), P);
      last_valid <= cyc;
    end
  end

  task automatic wait_valid();
    do @(negedge clk); while (!valid);
  endtask

  // settle, then check two successive held samples
  task automatic measure(input string req, input int exp);
    repeat (3) wait_valid();
    check(req, phase, exp);
    check({req, " deg R7"}, deg, exp_deg(exp));
    @(negedge clk);
    check("R5 valid single cycle", valid, 0);
    check("R6 held between pulses", phase, exp);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    check("R8 phase in reset", phase, 0);
    check("R8 deg in reset", deg, 0);
    check("R8 valid in reset", valid, 0);
    @(negedge clk) rst = 1'b0;

    // R2: no reference edge -> zero
    cmp_en = 1'b1; ref_en = 1'b0; gen_d = 10;
    measure("R2 no set", 0);

    // R1: reference only -> full count
    cmp_en = 1'b0; ref_en = 1'b1;
    measure("R1 latch stays set", P);

    cmp_en = 1'b1;
    // R3: same cycle edges
    gen_d = 0; measure("R3 coincident edges", 0);
    // R4 extremes and midpoint
    gen_d = 1;     measure("R4 offset 1", 1);
    gen_d = P - 1; measure("R4 offset max", P - 1);
    gen_d = P / 2; measure("R4 offset half", P / 2);

    // R9: wide reference pulse still high when cleared
    gen_d = 8; ref_w = 40; cmp_w = 3;
    measure("R9 wide ref pulse", 8);
    ref_w = 5; cmp_w = 5;

    // R4: random offsets, placements and widths
    for (int i = 0; i < 20; i++) begin
      gen_d  = $urandom_range(P - 1, 0);
      ref_at = $urandom_range(P - 1, 0);
      ref_w  = $urandom_range(P - 2, 1);
      cmp_w  = $urandom_range(P - 2, 1);
      measure("R4 random offset", gen_d);
    end

    // R8: reset mid-run clears outputs
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 phase after reset", phase, 0);
    check("R8 valid after reset", valid, 0);
    finish_run();
  end

  always @(posedge rst) last_valid <= -1;

endmodule